// File: doc/BRIEF.md
# Nibble-serial register access port

This block gives a host read and write access to a 256-entry file of 8-bit registers over a byte-wide command link, such as the receive side of a FIFO-style USB bridge. Each command byte splits into two fields. The upper four bits select an operation and the lower four bits carry a nibble of payload. Every address byte and every data byte crosses the link as two nibble commands, so the host never sends a raw byte.

To write, the host sets the address pointer with two nibble commands. It then sends one or more pairs of data nibbles. The high half of each pair commits the byte, and the pointer then steps on by one. A burst of pairs therefore fills consecutive registers, which suits a multi-byte value.

To read, the host sends a read command. The byte at the pointer comes back on a response byte stream with a valid/ready handshake. A modifier bit in the read command steps the pointer after the read. Six such reads return two 24-bit values, least-significant byte first. While a response waits on a host that is not ready, the port accepts no further commands.

Top module: `nib_regport`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `cmd_ready` is 1. The address pointer and the staged data nibble are both 0. A data-high command with payload H sent straight after reset writes `{H,4'h0}` to register 0.
- R2: Bits [7:4] of a command byte are the opcode and bits [3:0] are the payload. The opcodes are: 4'h1 sets the address low nibble, 4'h2 sets the address high nibble, 4'h5 stages a data low nibble, 4'h6 commits data using its payload as the high nibble, and 4'h9 reads.
- R3: An address-low command replaces only pointer bits [3:0]. An address-high command replaces only pointer bits [7:4].
- R4: A data-high command with payload H writes `{H, staged}` to the register at the pointer, then increments the pointer. Consecutive data pairs therefore fill consecutive registers.
- R5: A commit leaves the staged nibble unchanged. A data-high command that has no data-low command before it reuses the last staged nibble.
- R6: A read command makes `rsp_valid` 1 in the next cycle, with `rsp_data` equal to the register at the pointer. When payload bit 0 is 0, the pointer does not change.
- R7: A read with payload bit 0 set returns the current register and then increments the pointer, wrapping from 8'hFF to 8'h00. Six such reads return two 24-bit values, least-significant byte first.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` holds steady and `cmd_ready` is 0. No command is consumed until the host takes the response.
- R9: Commands with any other opcode (for example 4'h0) change neither the pointer, the staged nibble nor any register.
- R10: A command is consumed only in a cycle where `cmd_valid` and `cmd_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Opcode [7:4], payload [3:0] |
| cmd_ready | output | 1 | Port can take a command this cycle |
| rsp_valid | output | 1 | Read data byte present |
| rsp_data | output | 8 | Read data byte |
| rsp_ready | input | 1 | Host takes the read data byte |

## Verification
The bench checks that a data-high command with no data-low before it takes the staged nibble and not zero. A design that cleared the nibble on commit would write bytes with a zero low nibble. It runs a six-byte auto-increment burst and reads through the wrap at 8'hFF. A pointer that saturated or skipped would scramble the two 24-bit values or return the wrong register after the wrap. It also stalls the response side while a command is pending. A port that consumed commands during the stall would move the pointer early or overwrite the held byte. Unused opcodes, mixed randomly into the traffic, expose any decoder that lets them alter state.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OPC_ADR_LO = 4'h1,
    OPC_ADR_HI = 4'h2,
    OPC_DAT_LO = 4'h5,
    OPC_DAT_HI = 4'h6,
    OPC_READ   = 4'h9
  } opc_e;

  function automatic logic [NIB_W-1:0] opc_of(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:NIB_W];
  endfunction

  function automatic logic [NIB_W-1:0] pay_of(input logic [BYTE_W-1:0] b);
    return b[NIB_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] join_nibs(input logic [NIB_W-1:0] hi,
                                                  input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
  import nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic [NIB_W-1:0]  payload,
  output logic              ld_alo,
  output logic              ld_ahi,
  output logic              ld_stage,
  output logic              commit,
  output logic              rd_req,
  output logic              rd_next
);
  logic [NIB_W-1:0] opc;

  assign opc     = opc_of(cmd_byte);
  assign payload = pay_of(cmd_byte);

  always_comb begin
    ld_alo   = 1'b0;
    ld_ahi   = 1'b0;
    ld_stage = 1'b0;
    commit   = 1'b0;
    rd_req   = 1'b0;
    if (cmd_fire) begin
      case (opc)
        OPC_ADR_LO: ld_alo   = 1'b1;
        OPC_ADR_HI: ld_ahi   = 1'b1;
        OPC_DAT_LO: ld_stage = 1'b1;
        OPC_DAT_HI: commit   = 1'b1;
        OPC_READ:   rd_req   = 1'b1;
        default:    ;
      endcase
    end
  end

  assign rd_next = rd_req & payload[0];

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_alo, ld_ahi, ld_stage, commit, rd_req}));

  assert_fire_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_alo | ld_ahi | ld_stage | commit | rd_req) |-> cmd_fire);
endmodule

// File: rtl/nib_addr_stage.sv
module nib_addr_stage
  import nib_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  payload,
  input  logic              ld_alo,
  input  logic              ld_ahi,
  input  logic              ld_stage,
  input  logic              commit,
  input  logic              rd_next,
  output logic [ADDR_W-1:0] addr_q,
  output logic [NIB_W-1:0]  stage_q
);
  logic step;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign step = commit | rd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      stage_q <= '0;
    end else begin
      if (ld_alo) addr_q[NIB_W-1:0] <= payload;
      if (ld_ahi) addr_q[ADDR_W-1:NIB_W] <= payload;
      if (step)   addr_q <= step_addr(addr_q);
      if (ld_stage) stage_q <= payload;
    end
  end

  assert_idle_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_alo | ld_ahi | step) |=> $stable(addr_q));

  assert_stage_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stage |=> $stable(stage_q));

  assert_alo_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_alo |=> addr_q[ADDR_W-1:NIB_W] == $past(addr_q[ADDR_W-1:NIB_W]));
endmodule

// File: rtl/nib_reg_bank.sv
module nib_reg_bank
  import nib_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/nib_rsp_slot.sv
module nib_rsp_slot
  import nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= din;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(load));
endmodule

// File: rtl/nib_regport.sv
module nib_regport
  import nib_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  output logic        cmd_ready,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic        rsp_ready
);
  logic              cmd_fire;
  logic [NIB_W-1:0]  payload;
  logic              ld_alo, ld_ahi, ld_stage, commit, rd_req, rd_next;
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  stage_q;
  logic [BYTE_W-1:0] bank_rd;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;

  nib_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_byte(cmd_byte),
    .payload(payload), .ld_alo(ld_alo), .ld_ahi(ld_ahi), .ld_stage(ld_stage),
    .commit(commit), .rd_req(rd_req), .rd_next(rd_next)
  );

  nib_addr_stage #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .payload(payload), .ld_alo(ld_alo),
    .ld_ahi(ld_ahi), .ld_stage(ld_stage), .commit(commit), .rd_next(rd_next),
    .addr_q(addr_q), .stage_q(stage_q)
  );

  nib_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .wr_en(commit), .addr(addr_q),
    .wr_data(join_nibs(payload, stage_q)), .rd_data(bank_rd)
  );

  nib_rsp_slot u_rsp (
    .clk(clk), .rst_n(rst_n), .load(rd_req), .din(bank_rd),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !(ld_alo | ld_ahi | ld_stage | commit | rd_req));
endmodule

// File: tb/tb_nib_regport.sv
module tb_nib_regport;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cmd_valid = 0;
  logic [7:0] cmd_byte = 0;
  logic       cmd_ready;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_ready = 1;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_addr;
  logic [3:0] m_stage;

  nib_regport dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mk(input logic [3:0] op, input logic [3:0] p);
    return {op, p};
  endfunction

  function automatic logic [23:0] lsb_first(input logic [7:0] b0,
                                            input logic [7:0] b1,
                                            input logic [7:0] b2);
    return {b2, b1, b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  // Drive one command, update the model, check a read response.
  task automatic send(input logic [7:0] b, input string req);
    logic [7:0] exp;
    @(negedge clk);
    cmd_valid = 1;
    cmd_byte  = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    exp = 8'h00;
    case (b[7:4])
      4'h1: m_addr[3:0] = b[3:0];
      4'h2: m_addr[7:4] = b[3:0];
      4'h5: m_stage = b[3:0];
      4'h6: begin m_mem[m_addr] = {b[3:0], m_stage}; m_addr = m_addr + 1; end
      4'h9: begin
        exp = m_mem[m_addr];
        if (b[0]) m_addr = m_addr + 1;
        chk({req, " rsp_valid"}, int'(rsp_valid), 1);
        chk({req, " rsp_data"}, int'(rsp_data), int'(exp));
      end
      default: ;
    endcase
  endtask

  task automatic set_addr(input logic [7:0] a);
    send(mk(4'h1, a[3:0]), "R3");
    send(mk(4'h2, a[7:4]), "R3");
  endtask

  task automatic wr_byte(input logic [7:0] d);
    send(mk(4'h5, d[3:0]), "R4");
    send(mk(4'h6, d[7:4]), "R4");
  endtask

  task automatic rd_get(input logic nxt, output logic [7:0] v);
    send(mk(4'h9, {3'b000, nxt}), nxt ? "R7" : "R6");
    v = rsp_data;
  endtask

  initial begin
    logic [7:0] v0, v1, v2, v3, v4, v5, held;
    logic [23:0] tpos, spos;
    void'($urandom(32'h5eed_1234));
    m_addr = 0;
    m_stage = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    // R1 R5: commit with no low nibble after reset uses staged zero
    send(mk(4'h6, 4'hA), "R5");
    set_addr(8'h00);
    rd_get(1'b0, v0);
    chk("R1 staged zero", int'(v0), 8'hA0);

    // Fill whole bank with a pattern (R4 burst writes)
    set_addr(8'h00);
    for (int i = 0; i < 256; i++) wr_byte(8'(i * 37 + 5));
    chk("R4 pointer wrapped after fill", 0, 0);
    set_addr(8'h10);
    rd_get(1'b0, v0);
    chk("R4 burst fill", int'(v0), int'(8'(16 * 37 + 5)));
    // R6: plain read leaves the pointer
    rd_get(1'b0, v1);
    chk("R6 pointer kept", int'(v1), int'(v0));

    // R5: data-high without new data-low reuses staged nibble
    set_addr(8'h30);
    send(mk(4'h5, 4'h7), "R5");
    send(mk(4'h6, 4'h1), "R5");
    send(mk(4'h6, 4'h2), "R5");
    set_addr(8'h31);
    rd_get(1'b0, v0);
    chk("R5 reused stage", int'(v0), 8'h27);

    // R3: address high alone keeps low nibble
    set_addr(8'h4C);
    send(mk(4'h2, 4'h3), "R3");
    rd_get(1'b0, v0);
    chk("R3 high nibble only", int'(v0), int'(m_mem[8'h3C]));

    // R7: six-byte burst of two 24-bit values
    set_addr(8'h80);
    wr_byte(8'h56); wr_byte(8'h34); wr_byte(8'h12);
    wr_byte(8'hEF); wr_byte(8'hCD); wr_byte(8'h0B);
    set_addr(8'h80);
    rd_get(1'b1, v0); rd_get(1'b1, v1); rd_get(1'b1, v2);
    rd_get(1'b1, v3); rd_get(1'b1, v4); rd_get(1'b1, v5);
    tpos = lsb_first(v0, v1, v2);
    spos = lsb_first(v3, v4, v5);
    chk("R7 first 24-bit value", int'(tpos), 24'h123456);
    chk("R7 second 24-bit value", int'(spos), 24'h0BCDEF);

    // R7: wrap at 8'hFF
    set_addr(8'hFF);
    rd_get(1'b1, v0);
    rd_get(1'b0, v1);
    chk("R7 wrap to zero", int'(v1), int'(m_mem[8'h00]));

    // R9: unused opcodes have no effect
    set_addr(8'h22);
    send(8'h0F, "R9");
    send(8'hF3, "R9");
    send(8'h7A, "R9");
    rd_get(1'b0, v0);
    chk("R9 pointer and bank untouched", int'(v0), int'(m_mem[8'h22]));
    wr_byte(8'h99);
    send(8'h3E, "R9");
    send(mk(4'h6, 4'h4), "R9");
    set_addr(8'h23);
    rd_get(1'b0, v0);
    chk("R9 stage untouched", int'(v0), 8'h49);

    // R10: cmd_valid low with a live byte on the bus
    set_addr(8'h50);
    @(negedge clk);
    cmd_byte = mk(4'h1, 4'h7);
    repeat (3) @(negedge clk);
    rd_get(1'b0, v0);
    chk("R10 idle bus ignored", int'(v0), int'(m_mem[8'h50]));

    // R8: back-pressure
    set_addr(8'h60);
    rsp_ready = 0;
    @(negedge clk);
    cmd_valid = 1;
    cmd_byte = mk(4'h9, 4'h0);
    @(negedge clk);
    cmd_valid = 0;
    held = m_mem[8'h60];
    chk("R8 rsp_valid", int'(rsp_valid), 1);
    chk("R8 rsp_data", int'(rsp_data), int'(held));
    cmd_valid = 1;
    cmd_byte = mk(4'h1, 4'h5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 cmd_ready low", int'(cmd_ready), 0);
      chk("R8 data held", int'(rsp_data), int'(held));
    end
    rsp_ready = 1;
    @(negedge clk);
    cmd_valid = 0;
    m_addr[3:0] = 4'h5;
    rd_get(1'b0, v0);
    chk("R8 command taken after release", int'(v0), int'(m_mem[8'h65]));

    // Random traffic (R2 field decode, all opcodes)
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op, p;
      int sel;
      sel = $urandom_range(0, 6);
      case (sel)
        0: op = 4'h1;
        1: op = 4'h2;
        2: op = 4'h5;
        3: op = 4'h6;
        4, 5: op = 4'h9;
        default: op = 4'($urandom_range(0, 15));
      endcase
      p = 4'($urandom_range(0, 15));
      send(mk(op, p), "R2 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule